// File: doc/BRIEF.md
# Multi-Channel DMA Control and Interrupt Register File

This block is the software-visible control surface of a multi-channel DMA engine. It sits behind a 32-bit word-addressed bus slave. Each channel owns a window of 0x2000 bytes, which is 2048 words. Inside that window the block holds:

- the descriptor pointers;
- the command, configuration and stream-command registers;
- the interrupt mask, raw, masked and acknowledge registers.

The block also tracks a small per-channel state: idle/reset, stopped or running. It does not walk descriptors or move data. That belongs to a separate transfer engine.

The engine talks to the block through sideband signals:

- **Engine to block:**
  - pulses that mark a channel as running;
  - a live end-of-list flag;
  - a source code for the stream command;
  - per-bit interrupt set pulses.
- **Block to engine:**
  - a strobe on each accepted command write, with the written word on a shared data output;
  - a strobe on each stream-command write, with the same shared data output.

Each channel drives one registered interrupt line. The line is high whenever any raw interrupt bit is set under its mask bit.

Top module: `dma_chan_regs`

## Requirements
- R1: Only full-word accesses (all four byte enables set) take effect. Any other access with `bus_sel` high raises `bus_err` in the next cycle, returns zero read data and changes no register. Read data appears on `bus_rdata` one cycle after the access and is zero in every cycle without a valid read.
- R2: The word address splits into three fields. Bits 5:0 select a register, bits 10:6 must be zero, and bits 11 and up select the channel. Word offsets: data 0x00, saved-data 0x16, saved-buffer 0x17, group 0x18, group-down 0x1F, command 0x20, config 0x21, status 0x22, mask 0x23, acknowledge 0x24, raw 0x25, masked 0x26, stream command 0x27. The pointer, config and stream-command registers read back what was written. Any other offset reads zero and ignores writes.
- R3: After reset every register reads zero except status, which reads 0x101 (source 1, state idle), and every interrupt line is low.
- R4: The state encodes as idle=1, stopped=2 and running=4. An engine run pulse sets running. A config write with bit 1 set gives stopped. A config write with bit 0 clear gives idle and overrides the stop bit. A config write overrides a run pulse in the same cycle.
- R5: Status reads as follows: the state in bits 2:0, the live end-of-list input in bit 5, and the stored stream-command source in bits 8 and up. The source loads from `src_val` on a `src_load` pulse.
- R6: A command write is accepted only when stored config bit 0 is 1 and the channel's `client_ok` is high. An accepted write stores the value, pulses `cmd_stb` for one cycle and presents the value on `stb_data`. A refused write leaves the command register unchanged and gives no strobe.
- R7: A stream-command write is always stored. It pulses `scmd_stb` for one cycle with the value on `stb_data`.
- R8: Each `intr_set` bit sets its raw interrupt bit. Writing the acknowledge register clears the raw bits written as one. A set and an acknowledge of the same bit in the same cycle leave the bit set. The acknowledge register always reads zero.
- R9: The masked register reads raw AND mask. `irq` is high exactly when the masked value is nonzero. It follows a set pulse, a mask write or an acknowledge write one cycle later.
- R10: Writes to the status, raw and masked registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | WADDR_W | Word address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the access |
| bus_err | output | 1 | Error response for narrow accesses |
| client_ok | input | NUM_CH | A client is attached to the channel |
| eng_run | input | NUM_CH | Engine marks the channel running |
| eng_eol | input | NUM_CH | Live end-of-list flag |
| src_load | input | NUM_CH | Load the stream-command source |
| src_val | input | NUM_CH*SRC_W | Source value per channel |
| intr_set | input | NUM_CH*INTR_W | Interrupt set pulses per channel |
| irq | output | NUM_CH | Interrupt line per channel |
| cmd_stb | output | NUM_CH | Accepted command write strobe |
| scmd_stb | output | NUM_CH | Stream-command write strobe |
| stb_data | output | 32 | Last full-word write value |

## Verification
The bench targets four corner cases, each with the failure it would expose:

- **Command gate.** The bench writes the command register with config enabled but no client, and with a client but config disabled. A design that used only one condition would strobe or store when it must not.
- **Same-cycle collisions.** The bench collides an interrupt set with an acknowledge of the same bit, and a run pulse with a config write. A design with the wrong priority loses the interrupt or reports running instead of stopped.
- **Narrow and misplaced writes.** The bench checks narrow writes, writes to read-only and unmapped offsets, and writes outside the register window. A design decoding too few address bits would alias onto real registers.
- **Interrupt line timing.** The interrupt line is compared every cycle against a behavioural model. Any extra or missing cycle of delay is caught.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
    localparam int WORD_W = 6;

    localparam logic [WORD_W-1:0] OFS_DATA   = 6'h00;
    localparam logic [WORD_W-1:0] OFS_SDATA  = 6'h16;
    localparam logic [WORD_W-1:0] OFS_SBUF   = 6'h17;
    localparam logic [WORD_W-1:0] OFS_GRP    = 6'h18;
    localparam logic [WORD_W-1:0] OFS_GDOWN  = 6'h1F;
    localparam logic [WORD_W-1:0] OFS_CMD    = 6'h20;
    localparam logic [WORD_W-1:0] OFS_CFG    = 6'h21;
    localparam logic [WORD_W-1:0] OFS_STAT   = 6'h22;
    localparam logic [WORD_W-1:0] OFS_MASK   = 6'h23;
    localparam logic [WORD_W-1:0] OFS_ACK    = 6'h24;
    localparam logic [WORD_W-1:0] OFS_RAW    = 6'h25;
    localparam logic [WORD_W-1:0] OFS_MASKED = 6'h26;
    localparam logic [WORD_W-1:0] OFS_SCMD   = 6'h27;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd1,
        ST_STOP = 3'd2,
        ST_RUN  = 3'd4
    } ch_state_e;
endpackage

// File: rtl/dcr_channel.sv
module dcr_channel
    import dcr_pkg::*;
#(
    parameter int INTR_W = 4,
    parameter int SRC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic [31:0]       wdata,
    input  logic              client_ok,
    input  logic              eng_run,
    input  logic              eng_eol,
    input  logic              src_load,
    input  logic [SRC_W-1:0]  src_val,
    input  logic [INTR_W-1:0] intr_set,
    output logic [31:0]       rd_data,
    output logic              irq,
    output logic              cmd_stb,
    output logic              scmd_stb
);
    typedef struct packed {
        logic [31:0]       data;
        logic [31:0]       sdata;
        logic [31:0]       sbuf;
        logic [31:0]       grp;
        logic [31:0]       gdown;
        logic [31:0]       cmd;
        logic [31:0]       cfg;
        logic [31:0]       scmd;
        logic [INTR_W-1:0] mask;
        logic [INTR_W-1:0] raw;
        ch_state_e         st;
        logic [SRC_W-1:0]  src;
        logic              irq;
        logic              cmd_stb;
        logic              scmd_stb;
    } ch_t;

    ch_t               ch_d, ch_q;
    logic [INTR_W-1:0] ack_bits;
    logic              cfg_wr;

    always_comb begin
        ch_d          = ch_q;
        ch_d.cmd_stb  = 1'b0;
        ch_d.scmd_stb = 1'b0;
        ack_bits      = '0;
        cfg_wr        = wr_en && (word == OFS_CFG);
        if (wr_en) begin
            case (word)
                OFS_DATA:  ch_d.data  = wdata;
                OFS_SDATA: ch_d.sdata = wdata;
                OFS_SBUF:  ch_d.sbuf  = wdata;
                OFS_GRP:   ch_d.grp   = wdata;
                OFS_GDOWN: ch_d.gdown = wdata;
                OFS_CFG:   ch_d.cfg   = wdata;
                OFS_MASK:  ch_d.mask  = wdata[INTR_W-1:0];
                OFS_ACK:   ack_bits   = wdata[INTR_W-1:0];
                OFS_CMD: begin
                    if (ch_q.cfg[0] && client_ok) begin
                        ch_d.cmd     = wdata;
                        ch_d.cmd_stb = 1'b1;
                    end
                end
                OFS_SCMD: begin
                    ch_d.scmd     = wdata;
                    ch_d.scmd_stb = 1'b1;
                end
                default: ;
            endcase
        end
        if (eng_run) ch_d.st = ST_RUN;
        if (cfg_wr) begin
            if (wdata[1])  ch_d.st = ST_STOP;
            if (!wdata[0]) ch_d.st = ST_IDLE;
        end
        if (src_load) ch_d.src = src_val;
        ch_d.raw = (ch_q.raw & ~ack_bits) | intr_set;
        ch_d.irq = |(ch_d.raw & ch_d.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q     <= '0;
            ch_q.st  <= ST_IDLE;
            ch_q.src <= SRC_W'(1);
        end else begin
            ch_q <= ch_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (word)
            OFS_DATA:   rd_data = ch_q.data;
            OFS_SDATA:  rd_data = ch_q.sdata;
            OFS_SBUF:   rd_data = ch_q.sbuf;
            OFS_GRP:    rd_data = ch_q.grp;
            OFS_GDOWN:  rd_data = ch_q.gdown;
            OFS_CMD:    rd_data = ch_q.cmd;
            OFS_CFG:    rd_data = ch_q.cfg;
            OFS_SCMD:   rd_data = ch_q.scmd;
            OFS_MASK:   rd_data[INTR_W-1:0] = ch_q.mask;
            OFS_RAW:    rd_data[INTR_W-1:0] = ch_q.raw;
            OFS_MASKED: rd_data[INTR_W-1:0] = ch_q.raw & ch_q.mask;
            OFS_STAT: begin
                rd_data[2:0]         = ch_q.st;
                rd_data[5]           = eng_eol;
                rd_data[8 +: SRC_W]  = ch_q.src;
            end
            default: ;
        endcase
    end

    assign irq      = ch_q.irq;
    assign cmd_stb  = ch_q.cmd_stb;
    assign scmd_stb = ch_q.scmd_stb;
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dcr_pkg::*;
#(
    parameter int NUM_CH  = 2,
    parameter int WADDR_W = 12,
    parameter int INTR_W  = 4,
    parameter int SRC_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [WADDR_W-1:0]        bus_addr,
    input  logic [3:0]                bus_be,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      bus_err,
    input  logic [NUM_CH-1:0]         client_ok,
    input  logic [NUM_CH-1:0]         eng_run,
    input  logic [NUM_CH-1:0]         eng_eol,
    input  logic [NUM_CH-1:0]         src_load,
    input  logic [NUM_CH*SRC_W-1:0]   src_val,
    input  logic [NUM_CH*INTR_W-1:0]  intr_set,
    output logic [NUM_CH-1:0]         irq,
    output logic [NUM_CH-1:0]         cmd_stb,
    output logic [NUM_CH-1:0]         scmd_stb,
    output logic [31:0]               stb_data
);
    localparam int WIN_W = 11;
    localparam int CH_W  = WADDR_W - WIN_W;
    localparam int GAP_W = WIN_W - WORD_W;

    typedef struct packed {
        logic [31:0] rdata;
        logic        err;
        logic [31:0] stb_data;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    logic [CH_W-1:0]   ch_idx;
    logic [WORD_W-1:0] word;
    logic              full_acc;
    logic              in_win;
    logic [31:0]       ch_rd [NUM_CH];
    logic [NUM_CH-1:0] ch_wr;
    logic [NUM_CH-1:0] ch_hit;

    assign ch_idx   = bus_addr[WADDR_W-1:WIN_W];
    assign word     = bus_addr[WORD_W-1:0];
    assign full_acc = (bus_be == 4'hF);
    assign in_win   = (bus_addr[WIN_W-1:WORD_W] == GAP_W'(0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign ch_hit[i] = (ch_idx == CH_W'(i));
            assign ch_wr[i]  = bus_sel && bus_wr && full_acc && in_win && ch_hit[i];
            dcr_channel #(
                .INTR_W(INTR_W),
                .SRC_W (SRC_W)
            ) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (ch_wr[i]),
                .word     (word),
                .wdata    (bus_wdata),
                .client_ok(client_ok[i]),
                .eng_run  (eng_run[i]),
                .eng_eol  (eng_eol[i]),
                .src_load (src_load[i]),
                .src_val  (src_val[i*SRC_W +: SRC_W]),
                .intr_set (intr_set[i*INTR_W +: INTR_W]),
                .rd_data  (ch_rd[i]),
                .irq      (irq[i]),
                .cmd_stb  (cmd_stb[i]),
                .scmd_stb (scmd_stb[i])
            );
        end
    endgenerate

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.rdata = '0;
        rsp_d.err   = bus_sel && !full_acc;
        if (bus_sel && !bus_wr && full_acc && in_win) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_hit[i]) rsp_d.rdata = ch_rd[i];
            end
        end
        if (bus_sel && bus_wr && full_acc) rsp_d.stb_data = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rdata = rsp_q.rdata;
    assign bus_err   = rsp_q.err;
    assign stb_data  = rsp_q.stb_data;
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
    parameter int NUM_CH = 2,
    parameter int INTR_W = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_sel,
    input logic                     bus_wr,
    input logic [3:0]               bus_be,
    input logic                     bus_err,
    input logic [NUM_CH-1:0]        client_ok,
    input logic [NUM_CH*INTR_W-1:0] intr_set,
    input logic [NUM_CH-1:0]        irq,
    input logic [NUM_CH-1:0]        cmd_stb,
    input logic [NUM_CH-1:0]        scmd_stb
);
    // R1
    narrow_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && (bus_be != 4'hF) |=> bus_err);

    // R1
    full_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && (bus_be != 4'hF)) |=> !bus_err);

    // R6
    cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_stb));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R6
            cmd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cmd_stb[i] |-> $past(bus_sel && bus_wr && (bus_be == 4'hF) && client_ok[i]));

            // R7
            scmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
                scmd_stb[i] |-> $past(bus_sel && bus_wr && (bus_be == 4'hF)));

            // R9
            irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq[i]) |-> $past((bus_sel && bus_wr) || (|intr_set[i*INTR_W +: INTR_W])));
        end
    endgenerate
endmodule

bind dma_chan_regs dcr_checker #(
    .NUM_CH(NUM_CH),
    .INTR_W(INTR_W)
) u_dcr_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_be   (bus_be),
    .bus_err  (bus_err),
    .client_ok(client_ok),
    .intr_set (intr_set),
    .irq      (irq),
    .cmd_stb  (cmd_stb),
    .scmd_stb (scmd_stb)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
    localparam int NCH = 2;
    localparam int AW  = 12;
    localparam int IW  = 4;
    localparam int SW  = 8;

    localparam logic [5:0] W_DATA = 6'h00, W_SDATA = 6'h16, W_SBUF = 6'h17,
        W_GRP = 6'h18, W_GDOWN = 6'h1F, W_CMD = 6'h20, W_CFG = 6'h21,
        W_STAT = 6'h22, W_MASK = 6'h23, W_ACK = 6'h24, W_RAW = 6'h25,
        W_MASKED = 6'h26, W_SCMD = 6'h27;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0] bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_err;
    logic [NCH-1:0] client_ok = '1;
    logic [NCH-1:0] eng_run = '0, eng_eol = '0, src_load = '0;
    logic [NCH*SW-1:0] src_val = '0;
    logic [NCH*IW-1:0] intr_set = '0;
    logic [NCH-1:0] irq, cmd_stb, scmd_stb;
    logic [31:0] stb_data;

    always #2 clk = ~clk;

    dma_chan_regs #(.NUM_CH(NCH), .WADDR_W(AW), .INTR_W(IW), .SRC_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .client_ok(client_ok),
        .eng_run(eng_run), .eng_eol(eng_eol), .src_load(src_load),
        .src_val(src_val), .intr_set(intr_set), .irq(irq), .cmd_stb(cmd_stb),
        .scmd_stb(scmd_stb), .stb_data(stb_data));

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;
    string cur_tag = "R2";

    // behavioural reference model
    logic [31:0] mreg [NCH][64];
    int          mst  [NCH];
    logic [SW-1:0] msrc [NCH];
    logic [IW-1:0] mraw [NCH];
    logic [IW-1:0] mmask [NCH];
    logic [31:0] e_rdata, e_stb;
    logic e_err;
    logic [NCH-1:0] e_irq, e_cmd, e_scmd;
    string e_tag;

    // pending engine pulses applied together with the next bus cycle
    logic [NCH-1:0] p_run = '0, p_sload = '0;
    logic [NCH*IW-1:0] p_set = '0;
    logic [NCH*SW-1:0] p_sval = '0;

    function automatic logic [31:0] mread(int c, logic [5:0] w);
        logic [31:0] v = '0;
        case (w)
            W_DATA, W_SDATA, W_SBUF, W_GRP, W_GDOWN, W_CMD, W_CFG, W_SCMD:
                v = mreg[c][w];
            W_MASK:   v = 32'(mmask[c]);
            W_RAW:    v = 32'(mraw[c]);
            W_MASKED: v = 32'(mraw[c] & mmask[c]);
            W_STAT:   v = (32'(msrc[c]) << 8) | (32'(eng_eol[c]) << 5) | 32'(mst[c]);
            default:  v = '0;
        endcase
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                for (int w = 0; w < 64; w++) mreg[c][w] = '0;
                mst[c] = 1; msrc[c] = SW'(1); mraw[c] = '0; mmask[c] = '0;
            end
            e_rdata = '0; e_err = 0; e_irq = '0; e_cmd = '0; e_scmd = '0; e_stb = '0;
        end else begin
            int c;
            logic [5:0] w;
            logic inwin, full, wgo;
            logic [IW-1:0] ackv [NCH];
            c = int'(bus_addr[AW-1]);
            w = bus_addr[5:0];
            inwin = (bus_addr[10:6] == 5'd0);
            full = (bus_be == 4'hF);
            wgo = bus_sel && bus_wr && full && inwin;
            e_rdata = (bus_sel && !bus_wr && full && inwin) ? mread(c, w) : 32'h0;
            e_err = bus_sel && !full;
            e_tag = cur_tag;
            e_cmd = '0; e_scmd = '0;
            for (int k = 0; k < NCH; k++) ackv[k] = '0;
            if (bus_sel && bus_wr && full) e_stb = bus_wdata;
            if (wgo) begin
                case (w)
                    W_DATA, W_SDATA, W_SBUF, W_GRP, W_GDOWN, W_CFG: mreg[c][w] = bus_wdata;
                    W_CMD: if (mreg[c][W_CFG][0] && client_ok[c]) begin
                        mreg[c][w] = bus_wdata; e_cmd[c] = 1'b1;
                    end
                    W_SCMD: begin mreg[c][w] = bus_wdata; e_scmd[c] = 1'b1; end
                    W_MASK: mmask[c] = bus_wdata[IW-1:0];
                    W_ACK:  ackv[c] = bus_wdata[IW-1:0];
                    default: ;
                endcase
            end
            for (int k = 0; k < NCH; k++) begin
                if (eng_run[k]) mst[k] = 4;
                if (wgo && c == k && w == W_CFG) begin
                    if (bus_wdata[1]) mst[k] = 2;
                    if (!bus_wdata[0]) mst[k] = 1;
                end
                if (src_load[k]) msrc[k] = src_val[k*SW +: SW];
                mraw[k] = (mraw[k] & ~ackv[k]) | intr_set[k*IW +: IW];
                e_irq[k] = |(mraw[k] & mmask[k]);
            end
            #1;
            if (!done) begin
                check(e_tag, bus_rdata, e_rdata);
                check("R1", 32'(bus_err), 32'(e_err));
                check("R9", 32'(irq), 32'(e_irq));
                check("R6", 32'(cmd_stb), 32'(e_cmd));
                check("R7", 32'(scmd_stb), 32'(e_scmd));
                if (e_cmd != 0 || e_scmd != 0) check("R6/R7 stb_data", stb_data, e_stb);
            end
        end
    end

    task automatic access(int c, logic [5:0] w, logic wr, logic [31:0] v,
                          logic [3:0] be, string tag, logic [4:0] gap = 5'd0);
        @(negedge clk);
        cur_tag = tag;
        bus_sel = 1'b1; bus_wr = wr; bus_be = be; bus_wdata = v;
        bus_addr = {c[0], gap, w};
        eng_run = p_run; intr_set = p_set; src_load = p_sload; src_val = p_sval;
        p_run = '0; p_set = '0; p_sload = '0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
        eng_run = '0; intr_set = '0; src_load = '0;
    endtask

    task automatic wr(int c, logic [5:0] w, logic [31:0] v, string tag);
        access(c, w, 1'b1, v, 4'hF, tag);
    endtask

    task automatic rd(int c, logic [5:0] w, string tag);
        access(c, w, 1'b0, 32'h0, 4'hF, tag);
        @(negedge clk);
    endtask

    task automatic engine_only();
        @(negedge clk);
        eng_run = p_run; intr_set = p_set; src_load = p_sload; src_val = p_sval;
        p_run = '0; p_set = '0; p_sload = '0;
        @(negedge clk);
        eng_run = '0; intr_set = '0; src_load = '0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R3 reset values
        @(negedge clk);
        check("R3 irq", 32'(irq), 32'h0);
        rd(0, W_STAT, "R3"); rd(1, W_STAT, "R3"); rd(0, W_CFG, "R3"); rd(1, W_MASK, "R3");
        // R2 map and storage
        wr(0, W_DATA, 32'h1234_5678, "R2"); rd(0, W_DATA, "R2");
        wr(1, W_GDOWN, 32'hCAFE_0001, "R2"); rd(1, W_GDOWN, "R2"); rd(0, W_GDOWN, "R2");
        wr(0, W_SBUF, 32'h0000_ABCD, "R2"); rd(0, W_SBUF, "R2");
        wr(0, 6'h30, 32'hFFFF_FFFF, "R2"); rd(0, 6'h30, "R2");
        access(0, W_DATA, 1'b1, 32'hDEAD_BEEF, 4'hF, "R2", 5'd1);
        rd(0, W_DATA, "R2");
        // R1 narrow access
        access(0, W_DATA, 1'b1, 32'h5555_5555, 4'h3, "R1");
        rd(0, W_DATA, "R1");
        access(0, W_DATA, 1'b0, 32'h0, 4'h1, "R1");
        // R6 command gate
        wr(0, W_CMD, 32'h0000_0011, "R6"); rd(0, W_CMD, "R6");
        wr(0, W_CFG, 32'h1, "R6");
        client_ok[0] = 1'b0;
        wr(0, W_CMD, 32'h0000_0022, "R6"); rd(0, W_CMD, "R6");
        client_ok[0] = 1'b1;
        wr(0, W_CMD, 32'h0000_00AB, "R6"); rd(0, W_CMD, "R6");
        // R4 state machine
        rd(0, W_STAT, "R4");
        p_run = 2'b01; engine_only(); rd(0, W_STAT, "R4");
        wr(0, W_CFG, 32'h3, "R4"); rd(0, W_STAT, "R4");
        p_run = 2'b01; engine_only(); rd(0, W_STAT, "R4");
        wr(0, W_CFG, 32'h2, "R4"); rd(0, W_STAT, "R4");
        p_run = 2'b01; wr(0, W_CFG, 32'h3, "R4"); rd(0, W_STAT, "R4");
        p_run = 2'b10; engine_only(); rd(1, W_STAT, "R4");
        // R5 status fields
        eng_eol = 2'b01; p_sload = 2'b01; p_sval = {8'h00, 8'h5A};
        engine_only(); rd(0, W_STAT, "R5");
        eng_eol = 2'b00; rd(0, W_STAT, "R5");
        // R7 stream command
        wr(1, W_SCMD, 32'h0000_0140, "R7"); rd(1, W_SCMD, "R7");
        // R10 read-only registers
        wr(0, W_STAT, 32'hFFFF_FFFF, "R10"); rd(0, W_STAT, "R10");
        wr(0, W_RAW, 32'hF, "R10"); rd(0, W_RAW, "R10");
        wr(0, W_MASKED, 32'hF, "R10"); rd(0, W_MASKED, "R10");
        // R8 raw and acknowledge
        p_set = {4'h0, 4'h5}; engine_only(); rd(0, W_RAW, "R8");
        wr(0, W_ACK, 32'h1, "R8"); rd(0, W_RAW, "R8"); rd(0, W_ACK, "R8");
        p_set = {4'h0, 4'h1}; wr(0, W_ACK, 32'h1, "R8"); rd(0, W_RAW, "R8");
        // R9 mask and irq
        wr(0, W_MASK, 32'h4, "R9"); rd(0, W_MASKED, "R9");
        wr(0, W_ACK, 32'h4, "R9"); rd(0, W_MASKED, "R9");
        p_set = {4'h8, 4'h0}; engine_only(); rd(1, W_MASKED, "R9");
        wr(1, W_MASK, 32'h8, "R9"); rd(1, W_MASKED, "R9");
        wr(1, W_MASK, 32'h0, "R9");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            int c;
            logic [5:0] w;
            logic [5:0] pick [14];
            pick = '{W_DATA, W_SDATA, W_SBUF, W_GRP, W_GDOWN, W_CMD, W_CFG,
                     W_STAT, W_MASK, W_ACK, W_RAW, W_MASKED, W_SCMD, 6'h3F};
            c = int'($urandom_range(0, 1));
            w = pick[$urandom_range(0, 13)];
            p_set = NCH*IW'($urandom_range(0, 255)) & {8{($urandom_range(0, 3) == 0)}};
            p_run = NCH'($urandom_range(0, 3)) & {2{($urandom_range(0, 7) == 0)}};
            client_ok = NCH'($urandom_range(0, 3));
            if ($urandom_range(0, 1) == 1) wr(c, w, $urandom, "R2");
            else rd(c, w, "R2");
        end
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule